// File: doc/BRIEF.md
# Codec Power State Sequencer

This block decides when the digital side of a voice codec may run, and in which order its parts wake up. It runs on a free-running system clock. It watches three inputs: the power-up pin, the PCM bit clock and the transmit frame sync. All three pass through two-flop synchronizers. If a serial clock shows no edge for a programmable number of system clocks, that clock counts as stopped.

With power-up low, everything is off, and that includes the reference. With power-up high but either clock stopped, only the reference runs. When both clocks are toggling, the sequencer enables the analog sections and the PLL, then waits for the PLL-locked flag. While it waits, a counter can raise a lock-timeout flag without leaving the wait. After lock, the analog outputs stay muted to signal ground for a fixed settle interval. Only after that interval do the PCM output drivers turn on. Losing a clock or the power-up input at any point drops straight back to the matching low-power state.

All outputs are registered and change on the same edge as the state register.

Top module: `codec_pwr_seq`

## Requirements
- R1: While reset is high, and on the first edge after it, the state is DOWN (state_o = 0). The ref, analog and PLL enables are low, rx_mute_o is high, pcm_oe_o is low and lock_timeout_o is low.
- R2: Once the synchronized power-up input is low, the next edge puts the block in DOWN (state code 0) from any state. In DOWN the ref, analog and PLL enables are all low. Power-up low takes priority over every other condition.
- R3: A serial clock counts as stopped when it shows no edge for ACT_TIMEOUT system clocks. With power-up high and either clock stopped, the block goes to SAVE (state code 1). In SAVE only ref_en_o is high.
- R4: From DOWN or SAVE, with power-up high and both clocks toggling, the block enters LOCK_WAIT (state code 2). In LOCK_WAIT the ref, analog and PLL enables are high, and the block stays there until pll_locked_i is high.
- R5: lock_timeout_o rises after exactly LOCK_TIMEOUT cycles spent in LOCK_WAIT. The block keeps waiting for lock, and the flag clears when the block leaves LOCK_WAIT.
- R6: When pll_locked_i is high in LOCK_WAIT, the block enters SETTLE (state code 3). It stays there for exactly SETTLE_CYCLES cycles and then enters ACTIVE (state code 4).
- R7: pcm_oe_o is high only in ACTIVE. rx_mute_o is high in every state except ACTIVE.
- R8: In DOWN and SAVE, tx_hiz_o is high when TX_HIZ is 1, and tx_gnd_o is high when TX_HIZ is 0. In all other states both are low.
- R9: A clock stop in LOCK_WAIT, SETTLE or ACTIVE returns the block to SAVE. Power-up going low in any of those states returns it to DOWN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_up_i | input | 1 | Power-up pin, asynchronous |
| bclk_i | input | 1 | PCM bit clock, sampled as data |
| fsync_i | input | 1 | Transmit frame sync, sampled as data |
| pll_locked_i | input | 1 | PLL lock flag, in the clk domain |
| state_o | output | 3 | Current state code |
| ref_en_o | output | 1 | Reference enable |
| analog_en_o | output | 1 | Analog sections enable |
| pll_en_o | output | 1 | PLL enable |
| rx_mute_o | output | 1 | Hold receive outputs at signal ground |
| tx_hiz_o | output | 1 | Transmit amplifier outputs high impedance |
| tx_gnd_o | output | 1 | Transmit amplifier outputs weakly grounded |
| pcm_oe_o | output | 1 | Open-drain PCM driver enable |
| lock_timeout_o | output | 1 | Lock not seen within the timeout |

## Verification
The bench measures the exact number of cycles spent in SETTLE and in LOCK_WAIT before the timeout flag rises. A counter that is off by one would shorten the mute window or raise the error one cycle early or late.

It stops one clock while ACTIVE and checks the state both before and after the inactivity window. A detector that never times out, or one that fires on the first missing edge, fails one of these two samples.

It also aborts a sequence from LOCK_WAIT by a clock stop and from SETTLE by dropping power-up. A design that finishes the sequence anyway would enable the PCM drivers with the analog side unsettled.

A running monitor flags any cycle in which the PCM drivers are enabled outside ACTIVE.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;
  typedef enum logic [2:0] {
    PS_DOWN   = 3'd0,
    PS_SAVE   = 3'd1,
    PS_LOCK   = 3'd2,
    PS_SETTLE = 3'd3,
    PS_ACTIVE = 3'd4
  } pwr_state_e;
endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/cps_activity.sv
module cps_activity #(
  parameter int TIMEOUT = 62500
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic active_o
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic          prev_q;
  logic [CW-1:0] idle_q;
  logic          edge_seen;

  assign edge_seen = sig_i ^ prev_q;

  // idle_q counts cycles since the last edge; activity drops once it saturates
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      idle_q   <= '0;
      active_o <= 1'b0;
    end else begin
      prev_q <= sig_i;
      if (edge_seen) begin
        idle_q   <= '0;
        active_o <= 1'b1;
      end else if (idle_q != LAST) begin
        idle_q <= idle_q + 1'b1;
      end else begin
        active_o <= 1'b0;
      end
    end
  end

  a_r3_edge_marks_active: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> active_o);

  a_r3_drop_only_when_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(active_o) |-> !$past(edge_seen));
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
  import codec_pwr_pkg::*;
#(
  parameter int ACT_TIMEOUT   = 62500,
  parameter int LOCK_TIMEOUT  = 2500000,
  parameter int SETTLE_CYCLES = 250000,
  parameter int TX_HIZ        = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_up_i,
  input  logic       bclk_i,
  input  logic       fsync_i,
  input  logic       pll_locked_i,
  output logic [2:0] state_o,
  output logic       ref_en_o,
  output logic       analog_en_o,
  output logic       pll_en_o,
  output logic       rx_mute_o,
  output logic       tx_hiz_o,
  output logic       tx_gnd_o,
  output logic       pcm_oe_o,
  output logic       lock_timeout_o
);
  localparam int TMAX = (LOCK_TIMEOUT > SETTLE_CYCLES) ? LOCK_TIMEOUT : SETTLE_CYCLES;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] LOCK_LAST   = TW'(LOCK_TIMEOUT - 1);
  localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_CYCLES - 1);
  localparam logic [TW-1:0] TSAT        = TW'(TMAX);
  localparam logic HIZ_SEL = (TX_HIZ != 0);

  logic [2:0]    sync_q;
  logic [1:0]    act;
  logic          pu_s;
  logic          both_act;
  pwr_state_e    state_q, nxt;
  logic [TW-1:0] tmr_q;
  logic          low_pwr;

  cps_sync #(.W(3)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({fsync_i, bclk_i, pwr_up_i}),
    .q_o (sync_q)
  );

  // one activity detector per serial clock: index 0 = bit clock, 1 = frame sync
  for (genvar g = 0; g < 2; g++) begin : g_act
    cps_activity #(.TIMEOUT(ACT_TIMEOUT)) u_act (
      .clk      (clk),
      .rst      (rst),
      .sig_i    (sync_q[g+1]),
      .active_o (act[g])
    );
  end

  assign pu_s     = sync_q[0];
  assign both_act = &act;

  always_comb begin
    nxt = state_q;
    if (!pu_s) begin
      nxt = PS_DOWN;
    end else begin
      case (state_q)
        PS_DOWN, PS_SAVE: nxt = both_act ? PS_LOCK : PS_SAVE;
        PS_LOCK: begin
          if (!both_act)        nxt = PS_SAVE;
          else if (pll_locked_i) nxt = PS_SETTLE;
        end
        PS_SETTLE: begin
          if (!both_act)                 nxt = PS_SAVE;
          else if (tmr_q == SETTLE_LAST) nxt = PS_ACTIVE;
        end
        PS_ACTIVE: if (!both_act) nxt = PS_SAVE;
        default: nxt = PS_DOWN;
      endcase
    end
  end

  assign low_pwr = (nxt == PS_DOWN) || (nxt == PS_SAVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= PS_DOWN;
      tmr_q          <= '0;
      ref_en_o       <= 1'b0;
      analog_en_o    <= 1'b0;
      pll_en_o       <= 1'b0;
      rx_mute_o      <= 1'b1;
      tx_hiz_o       <= HIZ_SEL;
      tx_gnd_o       <= !HIZ_SEL;
      pcm_oe_o       <= 1'b0;
      lock_timeout_o <= 1'b0;
    end else begin
      state_q <= nxt;
      if (nxt != state_q)  tmr_q <= '0;
      else if (tmr_q != TSAT) tmr_q <= tmr_q + 1'b1;
      lock_timeout_o <= (nxt == PS_LOCK) && (state_q == PS_LOCK) &&
                        (lock_timeout_o || (tmr_q == LOCK_LAST));
      ref_en_o    <= (nxt != PS_DOWN);
      analog_en_o <= !low_pwr;
      pll_en_o    <= !low_pwr;
      rx_mute_o   <= (nxt != PS_ACTIVE);
      pcm_oe_o    <= (nxt == PS_ACTIVE);
      tx_hiz_o    <= low_pwr && HIZ_SEL;
      tx_gnd_o    <= low_pwr && !HIZ_SEL;
    end
  end

  assign state_o = state_q;

  a_r2_pu_low_forces_down: assert property (@(posedge clk) disable iff (rst)
    !pu_s |=> (state_q == PS_DOWN) && !ref_en_o && !pll_en_o);

  a_r3_idle_clock_save: assert property (@(posedge clk) disable iff (rst)
    pu_s && !both_act |=> (state_q == PS_SAVE) && ref_en_o && !analog_en_o);

  a_r4_wait_for_lock: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_LOCK) && !pll_locked_i |=> state_q != PS_SETTLE);

  a_r5_flag_in_lock_only: assert property (@(posedge clk) disable iff (rst)
    lock_timeout_o |-> state_q == PS_LOCK);

  a_r7_oe_after_settle: assert property (@(posedge clk) disable iff (rst)
    $rose(pcm_oe_o) |-> $past(state_q) == PS_SETTLE);

  a_r7_oe_unmuted: assert property (@(posedge clk) disable iff (rst)
    pcm_oe_o |-> !rx_mute_o && analog_en_o);
endmodule

// File: tb/codec_pwr_seq_bench.sv
module codec_pwr_seq_bench;
  localparam int ACT_T  = 40;
  localparam int LOCK_T = 100;
  localparam int SET_T  = 50;

  typedef struct packed {
    logic       pu;
    logic       br;
    logic       fr;
    logic       lk;
    logic [7:0] wt;
    logic [2:0] st;
  } vec_t;

  // pu, bclk running, fsync running, lock, cycles to wait, expected state code
  localparam vec_t VECS [0:7] = '{
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'd20,  3'd0},  // R2 stays down
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'd60,  3'd1},  // R3 bit clock static
    '{1'b1, 1'b1, 1'b1, 1'b0, 8'd30,  3'd2},  // R4 both clocks, no lock
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'd20,  3'd3},  // R6 settling
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'd40,  3'd4},  // R7 active
    '{1'b1, 1'b1, 1'b0, 1'b1, 8'd60,  3'd1},  // R9 frame sync lost
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'd100, 3'd4},  // R6 re-sequence
    '{1'b0, 1'b1, 1'b1, 1'b1, 8'd10,  3'd0}   // R2 power-up low
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_up = 1'b0, bclk = 1'b0, fsync = 1'b0, locked = 1'b0;
  logic bclk_run = 1'b1, fs_run = 1'b1;
  int   bdiv = 0, fdiv = 0;
  logic [2:0] state;
  logic ref_en, ana_en, pll_en, mute, hiz, gnd, oe, lto;
  int   checks = 0, fails = 0, oe_bad = 0;

  always #2 clk = ~clk;

  codec_pwr_seq #(
    .ACT_TIMEOUT(ACT_T), .LOCK_TIMEOUT(LOCK_T), .SETTLE_CYCLES(SET_T), .TX_HIZ(1)
  ) u_codec_pwr_seq (
    .clk(clk), .rst(rst), .pwr_up_i(pwr_up), .bclk_i(bclk), .fsync_i(fsync),
    .pll_locked_i(locked), .state_o(state), .ref_en_o(ref_en), .analog_en_o(ana_en),
    .pll_en_o(pll_en), .rx_mute_o(mute), .tx_hiz_o(hiz), .tx_gnd_o(gnd),
    .pcm_oe_o(oe), .lock_timeout_o(lto)
  );

  always @(negedge clk) begin
    if (bclk_run) begin
      if (bdiv == 2) begin bdiv <= 0; bclk <= ~bclk; end
      else bdiv <= bdiv + 1;
    end
    if (fs_run) begin
      if (fdiv == 14) begin fdiv <= 0; fsync <= ~fsync; end
      else fdiv <= fdiv + 1;
    end
    if (!rst && oe && state != 3'd4) oe_bad <= oe_bad + 1;  // R7 monitor
  end

  function automatic logic [6:0] exp_out(input logic [2:0] st);
    logic lp;
    lp = (st == 3'd0) || (st == 3'd1);
    return {st != 3'd0, !lp, !lp, st != 3'd4, lp, 1'b0, st == 3'd4};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // state and all enables against the per-state rules of R2 to R8
  task automatic chk_state(input string req, input logic [2:0] st);
    chk(req, {state, ref_en, ana_en, pll_en, mute, hiz, gnd, oe},
        {st, exp_out(st)});
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string row_req(input int i);
    case (i)
      0, 7:    return "R2";
      1:       return "R3";
      2:       return "R4";
      3, 6:    return "R6";
      4:       return "R7";
      default: return "R9";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog: actual hung expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    cyc(5);
    // R1 reset state
    chk("R1 reset", {state, ref_en, ana_en, pll_en, mute, oe, lto}, {3'd0, 6'b000100});
    chk("R8 reset tx hiz", {hiz, gnd}, 2'b10);
    rst = 1'b0;
    cyc(1);
    chk_state("R1 first edge after reset", 3'd0);

    for (int i = 0; i < 8; i++) begin
      pwr_up = VECS[i].pu; bclk_run = VECS[i].br; fs_run = VECS[i].fr;
      locked = VECS[i].lk;
      cyc(int'(VECS[i].wt));
      chk_state(row_req(i), VECS[i].st);
    end

    // R5 lock timeout window, then R6 exact settle length
    locked = 1'b0; pwr_up = 1'b1;
    for (int i = 0; i < 100 && state != 3'd2; i++) cyc(1);
    n = 0;
    for (int i = 0; i < 400 && state == 3'd2 && !lto; i++) begin n++; cyc(1); end
    chk("R5 cycles before timeout", n, LOCK_T);
    cyc(20);
    chk("R5 still waiting with flag", {state, lto}, {3'd2, 1'b1});
    locked = 1'b1;
    cyc(1);
    n = 0;
    for (int i = 0; i < 400 && state == 3'd3; i++) begin
      n++;
      if (oe || !mute || lto) oe_bad++;
      cyc(1);
    end
    chk("R6 settle length", n, SET_T);
    chk("R5 flag cleared after lock", {state, lto}, {3'd4, 1'b0});

    // R3 inactivity window on the bit clock
    bclk_run = 1'b0;
    cyc(30);
    chk_state("R3 still active inside window", 3'd4);
    cyc(25);
    chk_state("R3 save after window", 3'd1);

    // R9 abort from lock wait by frame sync loss
    locked = 1'b0; bclk_run = 1'b1;
    cyc(15);
    chk_state("R4 entered lock wait", 3'd2);
    fs_run = 1'b0;
    cyc(60);
    chk_state("R9 lock wait aborted to save", 3'd1);

    // R9 abort from settle by power-up low
    fs_run = 1'b1; locked = 1'b1;
    for (int i = 0; i < 100 && state != 3'd3; i++) cyc(1);
    pwr_up = 1'b0;
    cyc(4);
    chk_state("R9 settle aborted to down", 3'd0);

    chk("R7 drivers off outside active", oe_bad, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule